// File: doc/BRIEF.md
# 16-bit Timer with Edge-Triggered Capture

A 16-bit up-counter whose count source is chosen between the system clock and an external count input. A prescaler divides the count ticks by 1, 2, 4 or 8. The external input can be taken through a two-flop synchronizer (synchronized counting) or through a single sampling flop with lower latency (unsynchronized counting). When the counter rolls over from all ones to zero, it sets an overflow flag. That flag stays set until firmware clears it.

Next to the counter sits a capture unit. It watches a capture pin through its own two-flop synchronizer and copies the full 16-bit count into a capture register when an event occurs. The event can be every falling edge, every rising edge, every fourth rising edge or every sixteenth rising edge. Each capture sets a capture flag for firmware. A new capture overwrites the register even if the previous value has not been read. Capture is only allowed while the time base is synchronized to the system clock. Any change of the capture mode restarts the rising-edge count.

Top module: `tmr16_capture`

## Requirements
- R1: While rst_ni is low, tmr_o, cap_val_o, ovf_flag_o and cap_flag_o are all zero.
- R2: With clk_sel_i=0 and pre_sel_i=0, tmr_o increases by exactly one on every clock cycle.
- R3: pre_sel_i codes 0, 1, 2 and 3 make the counter advance once per 1, 2, 4 and 8 count ticks respectively. Over any window of 8 times that many ticks, the count grows by 8.
- R4: With clk_sel_i=1, the counter advances only on rising edges of ext_clk_i. With sync_en_i=1 the input passes through two synchronizer flops; with sync_en_i=0 it passes through one sampling flop. In either case every pulse is counted, and the counter holds while ext_clk_i is steady.
- R5: When the counter advances from 16'hFFFF, it becomes 0 and ovf_flag_o is set in the same cycle. The flag stays set until ovf_clr_i is high at a clock edge. If a new overflow occurs in the same cycle as a clear, the flag stays set.
- R6: cap_pin_i passes through two synchronizer flops before edge detection. On an event, cap_val_o takes the count value held during the second clock cycle after the pin change. This becomes visible after the third clock edge.
- R7: The cap_mode_i codes are: 0 = off, 1 = every falling edge, 2 = every rising edge, 3 = every 4th rising edge, 4 = every 16th rising edge, and 5 to 7 = off. Edges that do not match the mode leave cap_val_o and cap_flag_o unchanged.
- R8: Every capture sets cap_flag_o, which stays set until cap_clr_i is high at a clock edge; a capture wins over a clear in the same cycle. A later capture overwrites cap_val_o whether or not the flag was cleared.
- R9: Any change of cap_mode_i clears the rising-edge count, and no capture occurs in the cycle of the change. After a switch into mode 3, exactly 4 new rising edges are needed for the next capture.
- R10: When clk_sel_i=1 and sync_en_i=0, no capture occurs on any pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 1 | Count source: 0 system clock, 1 external input |
| ext_clk_i | input | 1 | External count input |
| sync_en_i | input | 1 | 1 selects synchronized external counting |
| pre_sel_i | input | 2 | Prescaler code, divide by 2^code |
| cap_pin_i | input | 1 | Capture pin |
| cap_mode_i | input | 3 | Capture event selection |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cap_clr_i | input | 1 | Clears the capture flag |
| tmr_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| cap_val_o | output | 16 | Captured count |
| cap_flag_o | output | 1 | Capture flag |

## Verification
The hardest case to reach is a stale rising-edge count that survives a mode change. The stimulus leaves three rising edges counted in the divide-by-16 mode and then switches to divide-by-4. If the count were not cleared, the very next edge would complete the divide-by-4 group. The bench checks that no capture follows that edge, and that the capture comes only on the fourth new edge. The rollover needs the full 65536-cycle count at divide-by-1. The bench waits for 16'hFFFF at the port and checks the wrap and the flag on the following cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    CAP_OFF    = 3'd0,
    CAP_FALL   = 3'd1,
    CAP_RISE   = 3'd2,
    CAP_RISE4  = 3'd3,
    CAP_RISE16 = 3'd4
  } cap_mode_e;

  localparam int unsigned EDGE_CNT_W = 4;
endpackage

// File: rtl/tmr16_clk_src.sv
module tmr16_clk_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_sel_i,
  input  logic sync_en_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_q, raw_prev_q;
  logic                   sync_rise, raw_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      sync_prev_q <= 1'b0;
      raw_q       <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_q       <= ext_clk_i;
      raw_prev_q  <= raw_q;
    end
  end

  assign sync_rise = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign raw_rise  = raw_q & ~raw_prev_q;

  always_comb begin
    if (!clk_sel_i)     tick_o = 1'b1;
    else if (sync_en_i) tick_o = sync_rise;
    else                tick_o = raw_rise;
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int unsigned TMR_W     = 16,
  parameter int unsigned PRE_SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [PRE_SEL_W-1:0] pre_sel_i,
  input  logic                 ovf_clr_i,
  output logic [TMR_W-1:0]     tmr_o,
  output logic                 ovf_o
);
  localparam int unsigned PRE_W = (1 << PRE_SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [TMR_W-1:0] tmr_q;
  logic             ovf_q, inc;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_mask[i] = (i < int'(pre_sel_i));
  end

  assign inc = tick_i && ((pre_q & pre_mask) == pre_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tick_i) pre_q <= pre_q + 1'b1;
      if (inc)    tmr_q <= tmr_q + 1'b1;
      if (inc && (&tmr_q)) ovf_q <= 1'b1;
      else if (ovf_clr_i)  ovf_q <= 1'b0;
    end
  end

  assign tmr_o = tmr_q;
  assign ovf_o = ovf_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !(&tmr_q)) |=> (tmr_q == $past(tmr_q) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc |=> $stable(tmr_q));
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && (&tmr_q)) |=> (ovf_q && tmr_q == '0));
endmodule

// File: rtl/tmr16_cap.sv
module tmr16_cap
  import tmr16_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = EDGE_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic [2:0]       mode_i,
  input  logic             cap_ok_i,
  input  logic             cap_clr_i,
  input  logic [TMR_W-1:0] tmr_i,
  output logic [TMR_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             evt_o
);
  logic [SYNC_STAGES-1:0] pin_q;
  logic                   pin_prev_q;
  logic [2:0]             mode_q;
  logic [CNT_W-1:0]       edge_cnt_q, lim;
  logic [TMR_W-1:0]       cap_q;
  logic                   flag_q;
  logic                   rise, fall, mode_chg, grouped, evt_raw;

  assign rise     = pin_q[SYNC_STAGES-1] & ~pin_prev_q;
  assign fall     = ~pin_q[SYNC_STAGES-1] & pin_prev_q;
  assign mode_chg = (mode_i != mode_q);
  assign grouped  = (mode_i == CAP_RISE4) || (mode_i == CAP_RISE16);
  assign lim      = (mode_i == CAP_RISE4) ? CNT_W'(3) : '1;

  always_comb begin
    case (mode_i)
      CAP_FALL:              evt_raw = fall;
      CAP_RISE:              evt_raw = rise;
      CAP_RISE4, CAP_RISE16: evt_raw = rise && (edge_cnt_q == lim);
      default:               evt_raw = 1'b0;
    endcase
  end

  assign evt_o = evt_raw && !mode_chg && cap_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q      <= '0;
      pin_prev_q <= 1'b0;
      mode_q     <= 3'(CAP_OFF);
      edge_cnt_q <= '0;
      cap_q      <= '0;
      flag_q     <= 1'b0;
    end else begin
      pin_q      <= {pin_q[SYNC_STAGES-2:0], cap_pin_i};
      pin_prev_q <= pin_q[SYNC_STAGES-1];
      mode_q     <= mode_i;
      if (mode_chg)             edge_cnt_q <= '0;
      else if (grouped && rise) edge_cnt_q <= (edge_cnt_q == lim) ? '0 : edge_cnt_q + 1'b1;
      if (evt_o) cap_q <= tmr_i;
      if (evt_o)          flag_q <= 1'b1;
      else if (cap_clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_val_o  = cap_q;
  assign cap_flag_o = flag_q;

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> (cap_val_o == $past(tmr_i) && cap_flag_o));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_clr_i && !evt_o) |=> !cap_flag_o);
  assert_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(cap_val_o));
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
  import tmr16_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_SEL_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clk_sel_i,
  input  logic                 ext_clk_i,
  input  logic                 sync_en_i,
  input  logic [PRE_SEL_W-1:0] pre_sel_i,
  input  logic                 cap_pin_i,
  input  logic [2:0]           cap_mode_i,
  input  logic                 ovf_clr_i,
  input  logic                 cap_clr_i,
  output logic [TMR_W-1:0]     tmr_o,
  output logic                 ovf_flag_o,
  output logic [TMR_W-1:0]     cap_val_o,
  output logic                 cap_flag_o
);
  logic tick, cap_evt;
  logic [TMR_W-1:0] tmr;

  tmr16_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni, .clk_sel_i, .sync_en_i, .ext_clk_i, .tick_o(tick)
  );

  tmr16_count #(.TMR_W(TMR_W), .PRE_SEL_W(PRE_SEL_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .pre_sel_i, .ovf_clr_i,
    .tmr_o(tmr), .ovf_o(ovf_flag_o)
  );

  tmr16_cap #(.TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i, .rst_ni, .cap_pin_i, .mode_i(cap_mode_i),
    .cap_ok_i(!clk_sel_i || sync_en_i), .cap_clr_i, .tmr_i(tmr),
    .cap_val_o, .cap_flag_o, .evt_o(cap_evt)
  );

  assign tmr_o = tmr;

  assert_async_nocap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i && !sync_en_i) |=> $stable(cap_val_o));
  assert_evt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_flag_o);
endmodule

// File: tb/sim_tmr16_capture.sv
module sim_tmr16_capture;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_sel = 1'b0, ext_clk = 1'b0, sync_en = 1'b1;
  logic [1:0] pre_sel = 2'd0;
  logic cap_pin = 1'b0;
  logic [2:0] cap_mode = 3'd0;
  logic ovf_clr = 1'b0, cap_clr = 1'b0;
  logic [15:0] tmr_o, cap_val_o;
  logic ovf_flag_o, cap_flag_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .ext_clk_i(ext_clk),
    .sync_en_i(sync_en), .pre_sel_i(pre_sel), .cap_pin_i(cap_pin),
    .cap_mode_i(cap_mode), .ovf_clr_i(ovf_clr), .cap_clr_i(cap_clr),
    .tmr_o(tmr_o), .ovf_flag_o(ovf_flag_o), .cap_val_o(cap_val_o),
    .cap_flag_o(cap_flag_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic pin_edge(input logic lvl, output logic [15:0] seen);
    cap_pin = lvl;
    @(negedge clk); @(negedge clk);
    seen = tmr_o;
    @(negedge clk);
  endtask

  task automatic clr_cap();
    cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    cap_mode = m; repeat (2) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 tmr", tmr_o, 0);
    chk("R1 cap", cap_val_o, 0);
    chk("R1 flags", {ovf_flag_o, cap_flag_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_internal();
    logic [15:0] a;
    @(negedge clk); a = tmr_o;
    repeat (10) @(negedge clk);
    chk("R2 count", tmr_o, 16'(a + 16'd10));
  endtask

  task automatic t_prescale();
    logic [15:0] a;
    for (int k = 0; k < 4; k++) begin
      pre_sel = 2'(k);
      a = tmr_o;
      repeat (8 << k) @(negedge clk);
      chk($sformatf("R3 div code %0d", k), tmr_o, 16'(a + 16'd8));
    end
    pre_sel = 2'd0;
  endtask

  task automatic t_external();
    logic [15:0] a;
    clk_sel = 1'b1; sync_en = 1'b1;
    repeat (4) @(negedge clk); a = tmr_o;
    ext_pulses(5); repeat (5) @(negedge clk);
    chk("R4 sync pulses", tmr_o, 16'(a + 16'd5));
    repeat (10) @(negedge clk);
    chk("R4 steady hold", tmr_o, 16'(a + 16'd5));
    sync_en = 1'b0; repeat (4) @(negedge clk); a = tmr_o;
    ext_pulses(5); repeat (5) @(negedge clk);
    chk("R4 async pulses", tmr_o, 16'(a + 16'd5));
    sync_en = 1'b1; pre_sel = 2'd2; repeat (4) @(negedge clk); a = tmr_o;
    ext_pulses(8); repeat (5) @(negedge clk);
    chk("R4 R3 ext div4", tmr_o, 16'(a + 16'd2));
    pre_sel = 2'd0; clk_sel = 1'b0;
  endtask

  task automatic t_overflow();
    int guard = 0;
    while (tmr_o !== 16'hFFFF && guard < 70000) begin @(negedge clk); guard++; end
    chk("R5 flag before wrap", ovf_flag_o, 0);
    @(negedge clk);
    chk("R5 wrap to zero", tmr_o, 0);
    chk("R5 flag set", ovf_flag_o, 1);
    repeat (3) @(negedge clk);
    chk("R5 flag held", ovf_flag_o, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R5 flag cleared", ovf_flag_o, 0);
  endtask

  task automatic t_capture_edges();
    logic [15:0] s, v;
    set_mode(3'd2); clr_cap();
    pin_edge(1'b1, s);
    chk("R6 R7 rise value", cap_val_o, s);
    chk("R8 flag set", cap_flag_o, 1);
    clr_cap();
    chk("R8 flag cleared", cap_flag_o, 0);
    v = cap_val_o;
    pin_edge(1'b0, s);
    chk("R7 fall ignored in rise mode", {cap_flag_o, cap_val_o}, {1'b0, v});
    set_mode(3'd1);
    pin_edge(1'b1, s);
    chk("R7 rise ignored in fall mode", {cap_flag_o, cap_val_o}, {1'b0, v});
    pin_edge(1'b0, s);
    chk("R7 fall value", {cap_flag_o, cap_val_o}, {1'b1, s});
    clr_cap();
    set_mode(3'd5);
    pin_edge(1'b1, s); pin_edge(1'b0, s);
    chk("R7 code 5 off", {cap_flag_o, cap_val_o}, {1'b0, v == v ? cap_val_o : v});
    v = cap_val_o;
    set_mode(3'd0);
    pin_edge(1'b1, s); pin_edge(1'b0, s);
    chk("R7 code 0 off", {cap_flag_o, cap_val_o}, {1'b0, v});
  endtask

  task automatic t_overwrite();
    logic [15:0] s1, s2, d;
    set_mode(3'd2); clr_cap();
    pin_edge(1'b1, s1); pin_edge(1'b0, d);
    pin_edge(1'b1, s2); pin_edge(1'b0, d);
    chk("R8 overwrite value", cap_val_o, s2);
    chk("R8 overwrite flag", cap_flag_o, 1);
    chk("R8 values differ", (s1 != s2), 1);
    clr_cap();
  endtask

  task automatic t_grouped(input logic [2:0] m, input int n);
    logic [15:0] s, d, v;
    set_mode(m); clr_cap(); v = cap_val_o;
    for (int i = 0; i < n - 1; i++) begin pin_edge(1'b1, s); pin_edge(1'b0, d); end
    chk($sformatf("R7 mode %0d early edges", m), {cap_flag_o, cap_val_o}, {1'b0, v});
    pin_edge(1'b1, s); pin_edge(1'b0, d);
    chk($sformatf("R7 mode %0d group edge", m), {cap_flag_o, cap_val_o}, {1'b1, s});
    clr_cap();
  endtask

  task automatic t_mode_change();
    logic [15:0] s, d, v;
    set_mode(3'd4); clr_cap(); v = cap_val_o;
    for (int i = 0; i < 3; i++) begin pin_edge(1'b1, s); pin_edge(1'b0, d); end
    set_mode(3'd3);
    pin_edge(1'b1, s); pin_edge(1'b0, d);
    chk("R9 no stale capture", {cap_flag_o, cap_val_o}, {1'b0, v});
    for (int i = 0; i < 3; i++) begin pin_edge(1'b1, s); pin_edge(1'b0, d); end
    chk("R9 fourth new edge", {cap_flag_o, cap_val_o}, {1'b1, s});
    clr_cap();
  endtask

  task automatic t_async_block();
    logic [15:0] s, d, v;
    set_mode(3'd2); clr_cap(); v = cap_val_o;
    clk_sel = 1'b1; sync_en = 1'b0; repeat (2) @(negedge clk);
    pin_edge(1'b1, s); pin_edge(1'b0, d);
    chk("R10 async blocks capture", {cap_flag_o, cap_val_o}, {1'b0, v});
    sync_en = 1'b1; repeat (2) @(negedge clk);
    pin_edge(1'b1, s); pin_edge(1'b0, d);
    chk("R10 sync allows capture", {cap_flag_o, cap_val_o}, {1'b1, s});
    clk_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_internal();
    t_prescale();
    t_external();
    t_capture_edges();
    t_overwrite();
    t_grouped(3'd3, 4);
    t_grouped(3'd4, 16);
    t_mode_change();
    t_async_block();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule